// File: doc/BRIEF.md
# GPIO Bank with Edge Capture

A register-mapped controller for one bank of general-purpose pins, up to 32 per bank. Software reads the synchronised pin levels, picks a direction per pin, drives output values only through write-one-to-set and write-one-to-clear words, and arms rising and/or falling edge capture per pin. Captured edges collect in a sticky status word that software clears by writing ones.

Interrupts come out on three level-sensitive lines. Pin 0 and pin 1 each own a line. Every higher pin shares a third line. The register bus is a plain single-cycle port: a write is taken on the clock edge where `bus_wr` is high, and read data is a combinational function of `bus_addr`. It has no handshake, so it never stalls and exerts no back-pressure. Bank width and the set of inverted-direction pins are parameters. Bits above the implemented width read as zero.

Register word offsets (byte address bits [4:2]): 0x00 level (read-only), 0x04 direction, 0x08 set (write-only), 0x0C clear (write-only), 0x10 rise arm, 0x14 fall arm, 0x18 edge status. Offset 0x1C reads zero.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction, output, rise-arm, fall-arm and status words are all zero, all three interrupt lines are low, and `pin_oe` equals the inverted-pin mask.
- R2: Reading offset 0x00 returns each pin's input as it stood two clock edges earlier (two-flop synchroniser), one bit per pin, with bit n for pin n.
- R3: Writing offset 0x08 drives high each pin whose data bit is 1 and leaves the others unchanged. Offset 0x08 reads as zero.
- R4: Writing offset 0x0C drives low each pin whose data bit is 1 and leaves the others unchanged. Offset 0x0C reads as zero.
- R5: Offset 0x04 reads back as written. `pin_oe[n]` is the direction bit for normal pins and its inverse for pins set in the inverted-pin mask.
- R6: With bit n of the rise-arm word (0x10) set, a 0-to-1 change of the synchronised pin n sets status bit n one clock later. A falling change alone does not.
- R7: With bit n of the fall-arm word (0x14) set, a 1-to-0 change sets status bit n. With both arms set, either change does. With neither set, no change does.
- R8: Writing offset 0x18 clears every status bit written as 1. Bits written as 0 keep their value.
- R9: When a captured edge and a status clear land on the same bit in the same cycle, the bit stays 1. Other bits in that clear are cleared.
- R10: `irq_pin0` follows status bit 0, `irq_pin1` follows status bit 1, and `irq_other` is the OR of status bits 2 and above.
- R11: An interrupt line stays high for as long as a status bit feeding it is set. It drops only after that bit is cleared.
- R12: Bits at or above the bank width read as zero in every register. Writes to the level register (0x00) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_addr | input | 5 | Byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Raw pin inputs, asynchronous |
| pin_out | output | NUM_PINS | Output values |
| pin_oe | output | NUM_PINS | Output enables, 1 drives the pin |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_other | output | 1 | Shared interrupt for pins 2 and up |

## Verification
Edge capture and a software clear of the status word can hit the same bit in the same cycle. The bench provokes this by changing a pin, counting the two synchroniser edges, and placing the clear write so that it is sampled on the same edge that records the new capture. It also has a second status bit with no new edge in that write. The result counts as correct only if the edge's bit remains 1 while the other cleared bit goes to 0. A matching clear with no concurrent edge confirms that the clear works at all.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BUS_AW = 5;
  localparam int BUS_DW = 32;

  // register select taken from byte address bits [4:2]
  typedef enum logic [2:0] {
    RS_LEVEL = 3'd0,
    RS_DIR   = 3'd1,
    RS_SET   = 3'd2,
    RS_CLR   = 3'd3,
    RS_RISE  = 3'd4,
    RS_FALL  = 3'd5,
    RS_STAT  = 3'd6,
    RS_NONE  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank_edge.sv
module gpio_bank_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_arm,
  input  logic [W-1:0] fall_arm,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] edge_hit,
  output logic [W-1:0] status
);
  logic [W-1:0] lvl_q;
  logic [W-1:0] rose, fell;

  assign rose     = lvl & ~lvl_q;
  assign fell     = ~lvl & lvl_q;
  assign edge_hit = (rose & rise_arm) | (fell & fall_arm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      status <= '0;
    end else begin
      lvl_q <= lvl;
      // a fresh capture outranks a clear on the same bit
      status <= (status & ~(clr_en ? clr_bits : '0)) | edge_hit;
    end
  end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int W = 32
) (
  input  logic [W-1:0] status,
  output logic         irq0,
  output logic         irq1,
  output logic         irq_rest
);
  assign irq0 = status[0];

  generate
    if (W > 1) begin : g_one
      assign irq1 = status[1];
    end else begin : g_no_one
      assign irq1 = 1'b0;
    end

    if (W > 2) begin : g_rest
      assign irq_rest = |status[W-1:2];
    end else begin : g_no_rest
      assign irq_rest = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int          NUM_PINS    = 32,
  parameter logic [31:0] INV_MASK    = 32'h0,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [BUS_AW-1:0]   bus_addr,
  input  logic [BUS_DW-1:0]   bus_wdata,
  output logic [BUS_DW-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_pin0,
  output logic                irq_pin1,
  output logic                irq_other
);
  localparam logic [NUM_PINS-1:0] INV = INV_MASK[NUM_PINS-1:0];

  reg_sel_e            sel;
  logic [NUM_PINS-1:0] wd;
  logic [NUM_PINS-1:0] lvl;
  logic [NUM_PINS-1:0] dir_q, out_q, rise_q, fall_q;
  logic [NUM_PINS-1:0] status_q, edge_hit;
  logic [NUM_PINS-1:0] rd_vec;
  logic                clr_en;

  assign sel    = reg_sel_e'(bus_addr[4:2]);
  assign wd     = bus_wdata[NUM_PINS-1:0];
  assign clr_en = bus_wr && (sel == RS_STAT);

  gpio_bank_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (bus_wr) begin
      case (sel)
        RS_DIR:  dir_q  <= wd;
        RS_SET:  out_q  <= out_q | wd;
        RS_CLR:  out_q  <= out_q & ~wd;
        RS_RISE: rise_q <= wd;
        RS_FALL: fall_q <= wd;
        default: ;
      endcase
    end
  end

  gpio_bank_edge #(.W(NUM_PINS)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (lvl),
    .rise_arm(rise_q),
    .fall_arm(fall_q),
    .clr_en  (clr_en),
    .clr_bits(wd),
    .edge_hit(edge_hit),
    .status  (status_q)
  );

  gpio_bank_irq #(.W(NUM_PINS)) u_irq (
    .status  (status_q),
    .irq0    (irq_pin0),
    .irq1    (irq_pin1),
    .irq_rest(irq_other)
  );

  always_comb begin
    case (sel)
      RS_LEVEL: rd_vec = lvl;
      RS_DIR:   rd_vec = dir_q;
      RS_RISE:  rd_vec = rise_q;
      RS_FALL:  rd_vec = fall_q;
      RS_STAT:  rd_vec = status_q;
      default:  rd_vec = '0;
    endcase
    bus_rdata = '0;
    bus_rdata[NUM_PINS-1:0] = rd_vec;
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q ^ INV;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [4:0]          bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic                irq_pin0,
  input logic                irq_pin1,
  input logic                irq_other,
  input logic [NUM_PINS-1:0] status,
  input logic [NUM_PINS-1:0] edge_hit
);
  localparam logic [31:0] PIN_MASK   = (NUM_PINS >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NUM_PINS) - 32'd1);
  localparam logic [31:0] OTHER_MASK = PIN_MASK & ~32'h3;

  logic [31:0] stat_w;
  assign stat_w = {{(32-NUM_PINS){1'b0}}, status} & PIN_MASK;

  // R3
  set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[4:2] == 3'd2) |=>
      ((pin_out & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

  // R4
  clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[4:2] == 3'd3) |=>
      ((pin_out & $past(bus_wdata[NUM_PINS-1:0])) == '0));

  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((status & $past(edge_hit)) == $past(edge_hit)));

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr && bus_addr[4:2] == 3'd6) && edge_hit == '0) |=> $stable(status));

  // R10
  irq_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pin0 == stat_w[0]) && (irq_pin1 == stat_w[1]) &&
    (irq_other == ((stat_w & OTHER_MASK) != 32'h0)));
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .pin_out  (pin_out),
  .irq_pin0 (irq_pin0),
  .irq_pin1 (irq_pin1),
  .irq_other(irq_other),
  .status   (status_q),
  .edge_hit (edge_hit)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int          N   = 6;
  localparam logic [31:0] INV = 32'h24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe;
  logic          irq_pin0, irq_pin1, irq_other;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_bank #(.NUM_PINS(N), .INV_MASK(INV)) u_gpio_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_pin0(irq_pin0),
    .irq_pin1(irq_pin1), .irq_other(irq_other)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // caller sits at a negedge; returns at the next negedge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    logic [N-1:0] model;
    logic [N-1:0] exp_st;

    cyc(2);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(5'(a*4), r);
      check("R1 reset register", r, 32'h0);
    end
    check("R1 reset pin_out", 32'(pin_out), 32'h0);
    check("R1 reset pin_oe", 32'(pin_oe), INV & 32'h3F);
    check("R1 reset irqs", {29'h0, irq_pin0, irq_pin1, irq_other}, 32'h0);

    // R3 / R4 set and clear sweep
    model = '0;
    for (int v = 0; v < 64; v++) begin
      wr(5'h08, 32'hFFFF_FFC0 | 32'(v));
      model = model | N'(v);
      check("R3 set", 32'(pin_out), 32'(model));
      wr(5'h0C, 32'((v * 5 + 3) & 63));
      model = model & ~N'((v * 5 + 3) & 63);
      check("R4 clear", 32'(pin_out), 32'(model));
    end
    rd(5'h08, r); check("R3 set reads zero", r, 32'h0);
    rd(5'h0C, r); check("R4 clear reads zero", r, 32'h0);

    // R5 direction sweep, R12 upper bits
    for (int d = 0; d < 64; d++) begin
      wr(5'h04, 32'hABCD_EF00 | 32'(d));
      rd(5'h04, r);
      check("R5 R12 direction readback", r, 32'(d));
      check("R5 output enable", 32'(pin_oe), 32'(d) ^ (INV & 32'h3F));
    end
    wr(5'h04, 32'h0);

    // R2 level sweep, two-edge latency
    for (int v = 0; v < 64; v++) begin
      pin_in = N'(v);
      cyc(2);
      rd(5'h00, r);
      check("R2 level", r, 32'(v));
    end
    // R12 write to level ignored
    wr(5'h00, 32'h0);
    rd(5'h00, r);
    check("R12 level write ignored", r, 32'h3F);
    pin_in = '0;
    cyc(4);

    // R6 R7 R8 R10 R11 edge sweep per pin and arm setting
    for (int p = 0; p < N; p++) begin
      for (int en = 0; en < 4; en++) begin
        wr(5'h10, 32'h0);
        wr(5'h14, 32'h0);
        pin_in = '0;
        cyc(4);
        wr(5'h18, 32'h3F);
        wr(5'h10, (en & 1) ? (32'h1 << p) : 32'h0);
        wr(5'h14, (en & 2) ? (32'h1 << p) : 32'h0);
        pin_in[p] = 1'b1;
        cyc(3);
        exp_st = (en & 1) ? N'(1 << p) : '0;
        rd(5'h18, r);
        check("R6 rise capture", r, 32'(exp_st));
        check("R10 irq mapping",
              {29'h0, irq_pin0, irq_pin1, irq_other},
              {29'h0, exp_st[0], exp_st[1], |exp_st[5:2]});
        pin_in[p] = 1'b0;
        cyc(3);
        if (en & 2) exp_st = exp_st | N'(1 << p);
        cyc(3);
        rd(5'h18, r);
        check("R7 R11 fall capture held", r, 32'(exp_st));
        check("R11 irq held",
              {29'h0, irq_pin0, irq_pin1, irq_other},
              {29'h0, exp_st[0], exp_st[1], |exp_st[5:2]});
        wr(5'h18, 32'h0);
        rd(5'h18, r);
        check("R8 zero write keeps status", r, 32'(exp_st));
        wr(5'h18, 32'h1 << p);
        rd(5'h18, r);
        check("R8 one write clears", r, 32'h0);
        check("R11 irqs drop", {29'h0, irq_pin0, irq_pin1, irq_other}, 32'h0);
      end
    end

    // R9 capture and clear in the same cycle
    wr(5'h14, 32'h0);
    wr(5'h10, 32'h18);
    pin_in = 6'h18;
    cyc(3);
    rd(5'h18, r);
    check("R9 setup", r, 32'h18);
    pin_in = '0;
    cyc(3);
    pin_in[3] = 1'b1;
    cyc(2);
    wr(5'h18, 32'h18);
    rd(5'h18, r);
    check("R9 edge beats clear", r, 32'h08);
    wr(5'h18, 32'h08);
    rd(5'h18, r);
    check("R9 plain clear", r, 32'h0);
    check("R10 irq_other low", 32'(irq_other), 32'h0);

    done = 1;
    finish_run();
  end
endmodule